// File: doc/BRIEF.md
# Reflected-Code Head Row Scanner

This block produces the row-select lines for a pair of print heads with 13 rows each. A 4-bit up/down counter steps through a fixed 14-state sequence in which consecutive codes differ in one bit. A decoder turns the active code into a one-hot 13-line row select, and the three codes that name no row leave every line inactive.

Four shared input pins serve two modes. With the internal-counter enable high, three of the pins act as a counter step strobe, a count direction and an active-low counter clear. With the enable low, all four pins form an external code that feeds the decoder directly, and the counter holds its state. A channel select steers the decoded lines to head A or head B. An active-low channel enable blanks both buses. Everything runs in the system clock domain. The step pin is sampled there and is expected to change far more slowly than the system clock, at no more than 1 MHz.

Top module: `head_row_scanner`

## Requirements
- R1: With intCountEn=1, pinS1=1 and pinS2=1, each rising edge seen on pinS0 advances the counter through 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1000, and then back to 0000.
- R2: With pinS2=0, each step walks the same 14 codes in reverse. From 0000 the counter goes to 1000, then 1010, then 1110.
- R3: Row k (bit k-1 of a row bus, for k=1..13) is selected by the k-th nonzero code of the R1 list (0001 selects row 1, 1000 selects row 13). The codes 0000, 1001 and 1011 select no row, and the row buses never carry more than one active bit.
- R4: With intCountEn=1, pinS1=0 clears the counter to 0000 on the next clock edge. The clear takes priority over a step.
- R5: With intCountEn=0, the code {pinS3,pinS2,pinS1,pinS0} drives the decoder with no clock delay. The counter keeps its state through any pin activity in this mode, including pulses on pinS0 and a low pinS1.
- R6: chanSel=0 sends the decoded row to rowA, and chanSel=1 sends it to rowB. The bus that is not selected is all zero.
- R7: chanEnN=1 forces all 26 row lines low.
- R8: The direction is taken from pinS2 at each step, so a sequence may reverse between steps without skipping or corrupting a code.
- R9: After rst_n is released, the counter holds 0000 and no row is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intCountEn | input | 1 | 1: counter mode, 0: external-code mode |
| pinS0 | input | 1 | Counter step strobe, or code bit 0 |
| pinS1 | input | 1 | Active-low counter clear, or code bit 1 |
| pinS2 | input | 1 | Count direction (1 = up), or code bit 2 |
| pinS3 | input | 1 | Code bit 3 (used in external mode only) |
| chanSel | input | 1 | 0 selects head A, 1 selects head B |
| chanEnN | input | 1 | Active-low output enable for both heads |
| rowA | output | 13 | Row select lines for head A |
| rowB | output | 13 | Row select lines for head B |

## Verification
A counter step is due one clock edge after pinS0 is first sampled high. The bench raises pinS0 at a falling edge, drops it at the next falling edge and compares the row buses at the falling edge after that. In external mode, and for the channel select and enable, the outputs follow the inputs combinationally, so the bench checks them a short delay after driving, well away from any rising edge. The counter clear takes effect at the next rising edge and is sampled at the falling edge that follows.

// File: rtl/head_scan_pkg.sv
package head_scan_pkg;
  localparam int CODE_W     = 4;
  localparam int NUM_ROWS   = 13;
  localparam int NUM_STATES = NUM_ROWS + 1;
  localparam int IDX_W      = $clog2(NUM_STATES);

  typedef struct packed {
    logic step;   // one-cycle advance request
    logic up;     // direction for this step
    logic clear;  // synchronous counter clear
  } scan_strobe_t;

  // Code at position n of the up-count sequence: reflected binary, except
  // the last position folds to MSB-only so that the wrap changes one bit.
  function automatic logic [CODE_W-1:0] seqCode(input int n);
    logic [CODE_W-1:0] g;
    g = CODE_W'(n) ^ (CODE_W'(n) >> 1);
    if (n == NUM_STATES - 1) g = {1'b1, {(CODE_W-1){1'b0}}};
    return g;
  endfunction
endpackage

// File: rtl/head_scan_ctrl.sv
module head_scan_ctrl
  import head_scan_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         intCountEn,
  input  logic         pinS0,
  input  logic         pinS1,
  input  logic         pinS2,
  output scan_strobe_t strobe
);
  logic s0Prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s0Prev <= 1'b0;
    else        s0Prev <= pinS0;
  end

  always_comb begin
    strobe.step  = intCountEn & pinS0 & ~s0Prev;
    strobe.up    = pinS2;
    strobe.clear = intCountEn & ~pinS1;
  end
endmodule

// File: rtl/head_scan_datapath.sv
module head_scan_datapath
  import head_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  scan_strobe_t        strobe,
  input  logic                intCountEn,
  input  logic [CODE_W-1:0]   extCode,
  input  logic                chanSel,
  input  logic                chanEnN,
  output logic [NUM_ROWS-1:0] rowA,
  output logic [NUM_ROWS-1:0] rowB,
  output logic [CODE_W-1:0]   cntCode
);
  logic [CODE_W-1:0]   cntNext;
  logic [CODE_W-1:0]   selCode;
  logic [NUM_ROWS-1:0] rowHot;

  function automatic logic [CODE_W-1:0] stepCode(input logic [CODE_W-1:0] cur,
                                                 input logic up);
    logic            found;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] nxt;
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_STATES; i++) begin
      if (cur == seqCode(i)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    if (up) nxt = (idx == IDX_W'(NUM_STATES - 1)) ? '0 : idx + 1'b1;
    else    nxt = (idx == '0) ? IDX_W'(NUM_STATES - 1) : idx - 1'b1;
    // An unlisted code re-enters the sequence at its origin.
    return found ? seqCode(int'(nxt)) : '0;
  endfunction

  always_comb begin
    cntNext = cntCode;
    if (strobe.clear)     cntNext = '0;
    else if (strobe.step) cntNext = stepCode(cntCode, strobe.up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cntCode <= '0;
    else        cntCode <= cntNext;
  end

  assign selCode = intCountEn ? cntCode : extCode;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign rowHot[r] = (selCode == seqCode(r + 1));
  end

  always_comb begin
    rowA = '0;
    rowB = '0;
    if (!chanEnN) begin
      if (chanSel) rowB = rowHot;
      else         rowA = rowHot;
    end
  end
endmodule

// File: rtl/head_row_scanner.sv
module head_row_scanner
  import head_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                intCountEn,
  input  logic                pinS0,
  input  logic                pinS1,
  input  logic                pinS2,
  input  logic                pinS3,
  input  logic                chanSel,
  input  logic                chanEnN,
  output logic [NUM_ROWS-1:0] rowA,
  output logic [NUM_ROWS-1:0] rowB
);
  scan_strobe_t      strobe;
  logic [CODE_W-1:0] cntCode;

  head_scan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .intCountEn (intCountEn),
    .pinS0      (pinS0),
    .pinS1      (pinS1),
    .pinS2      (pinS2),
    .strobe     (strobe)
  );

  head_scan_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .intCountEn (intCountEn),
    .extCode    ({pinS3, pinS2, pinS1, pinS0}),
    .chanSel    (chanSel),
    .chanEnN    (chanEnN),
    .rowA       (rowA),
    .rowB       (rowB),
    .cntCode    (cntCode)
  );
endmodule

// File: rtl/head_scan_checker.sv
module head_scan_checker
  import head_scan_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                intCountEn,
  input logic                pinS1,
  input logic                chanSel,
  input logic                chanEnN,
  input logic [NUM_ROWS-1:0] rowA,
  input logic [NUM_ROWS-1:0] rowB,
  input logic [CODE_W-1:0]   cntCode
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rowA) && $onehot0(rowB));

  p_one_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chanSel |-> (rowA == '0));

  p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chanEnN |-> (rowA == '0 && rowB == '0));

  p_hold_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !intCountEn |=> $stable(cntCode));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (intCountEn && !pinS1) |=> (cntCode == '0));
endmodule

bind head_row_scanner head_scan_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .intCountEn (intCountEn),
  .pinS1      (pinS1),
  .chanSel    (chanSel),
  .chanEnN    (chanEnN),
  .rowA       (rowA),
  .rowB       (rowB),
  .cntCode    (cntCode)
);

// File: tb/head_row_scanner_tb.sv
module head_row_scanner_tb;
  localparam int PERIOD = 10;
  localparam logic [3:0] UP_SEQ [14] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5,
                                         4'h4, 4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'h8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intCountEn = 1'b1;
  logic pinS0 = 1'b0, pinS1 = 1'b1, pinS2 = 1'b1, pinS3 = 1'b0;
  logic chanSel = 1'b0, chanEnN = 1'b0;
  logic [12:0] rowA, rowB;
  int total = 0;
  int bad = 0;
  int expIdx = 0;

  always #(PERIOD/2) clk = ~clk;

  head_row_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .intCountEn(intCountEn),
    .pinS0(pinS0), .pinS1(pinS1), .pinS2(pinS2), .pinS3(pinS3),
    .chanSel(chanSel), .chanEnN(chanEnN), .rowA(rowA), .rowB(rowB)
  );

  function automatic logic [12:0] rowFor(input logic [3:0] code);
    logic [12:0] r;
    r = '0;
    for (int i = 1; i < 14; i++)
      if (UP_SEQ[i] == code) r = 13'(1) << (i - 1);
    return r;
  endfunction

  task automatic check(input string tag, input logic [12:0] expA, input logic [12:0] expB);
    total++;
    if (rowA !== expA || rowB !== expB) begin
      bad++;
      $display("FAIL %s: rowA=%h rowB=%h expected rowA=%h rowB=%h", tag, rowA, rowB, expA, expB);
    end
  endtask

  task automatic stepPulse(input logic up);
    @(negedge clk); pinS2 = up; pinS0 = 1'b1;
    @(negedge clk); pinS0 = 1'b0;
    @(negedge clk);
    if (up) expIdx = (expIdx == 13) ? 0 : expIdx + 1;
    else    expIdx = (expIdx == 0) ? 13 : expIdx - 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset state", '0, '0);

    // R1: full up walk with wrap
    for (int k = 0; k < 15; k++) begin
      stepPulse(1'b1);
      check($sformatf("R1 up step %0d", k), rowFor(UP_SEQ[expIdx]), '0);
    end

    // R4: clear back to 0000, clear wins over a step
    @(negedge clk); pinS1 = 1'b0; pinS0 = 1'b1;
    @(negedge clk); pinS1 = 1'b1; pinS0 = 1'b0;
    expIdx = 0;
    check("R4 clear with step", '0, '0);

    // R2: full down walk with wrap
    for (int k = 0; k < 15; k++) begin
      stepPulse(1'b0);
      check($sformatf("R2 down step %0d", k), rowFor(UP_SEQ[expIdx]), '0);
    end

    // R8: direction reversal between steps
    @(negedge clk); pinS1 = 1'b0;
    @(negedge clk); pinS1 = 1'b1; expIdx = 0;
    for (int k = 0; k < 3; k++) stepPulse(1'b1);
    for (int k = 0; k < 2; k++) stepPulse(1'b0);
    stepPulse(1'b1);
    check("R8 reversal", rowFor(UP_SEQ[2]), '0);
    for (int k = 0; k < 3; k++) stepPulse(1'b1);
    check("R8 after reversal", rowFor(UP_SEQ[5]), '0);

    // R6 / R7 in counter mode
    chanSel = 1'b1; #1;
    check("R6 head B counter", '0, rowFor(UP_SEQ[5]));
    chanEnN = 1'b1; #1;
    check("R7 blank counter", '0, '0);
    chanSel = 1'b0; chanEnN = 1'b0;

    // R5 / R3 / R6 / R7: external code sweep
    @(negedge clk); intCountEn = 1'b0;
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        {pinS3, pinS2, pinS1, pinS0} = 4'(c);
        chanSel = m[0]; chanEnN = m[1];
        #1;
        if (chanEnN) check($sformatf("R7 ext code %0d", c), '0, '0);
        else if (chanSel) check($sformatf("R3 R6 ext code %0d head B", c), '0, rowFor(4'(c)));
        else check($sformatf("R3 R5 ext code %0d head A", c), rowFor(4'(c)), '0);
        #2;
      end
    end

    // R5: counter holds through pin activity in external mode
    chanSel = 1'b0; chanEnN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pinS0 = 1'b1; pinS1 = 1'b0;
      @(negedge clk); pinS0 = 1'b0;
    end
    @(negedge clk); pinS1 = 1'b1; pinS2 = 1'b1; pinS3 = 1'b0; intCountEn = 1'b1;
    @(negedge clk);
    check("R5 counter held", rowFor(UP_SEQ[5]), '0);
    stepPulse(1'b1);
    check("R5 resume counting", rowFor(UP_SEQ[6]), '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule